// File: doc/BRIEF.md
# Machine-Cycle Timer with Modulo Reload

This block is a small timer for an 8-bit microcontroller system. A 16-bit divider counts machine-cycle enable pulses without stopping. Its upper byte can be read over the register bus. An 8-bit step counter advances whenever a chosen divider tap rolls over. When the step counter passes its maximum, it does not wrap to zero. It takes the value of a separate modulo register, and one cycle later the block raises a single-cycle interrupt request.

Software reaches four byte registers in the I/O page through a simple bus made of an offset, write data, a write strobe and combinational read data. The interrupt request goes to an external interrupt controller, which latches it into its own flag register. The clock enable input pulses once per machine cycle. Every timing rule below is counted in those pulses.

Top module: `prog_timer`

## Requirements
- R1: The 16-bit divider adds one on each clock edge where `cke` is high and the divider is not being written. Reading offset 0x04 returns divider bits 15:8.
- R2: Any write to offset 0x04 sets all 16 divider bits to zero, whatever the write data. This clear takes priority over a `cke` pulse in the same cycle, and no counter step happens in that cycle.
- R3: Bits 1:0 of the control register (offset 0x07) select the step period in `cke` pulses: 2'b01 gives 16, 2'b10 gives 64, 2'b11 gives 256 and 2'b00 gives 1024. A step happens on the `cke` edge that carries the divider's low bits of that period from all ones back to zero.
- R4: Control bit 2 enables stepping. While it is 0, the step counter (offset 0x05) holds its value.
- R5: A step from 0xFF loads the counter with the value the modulo register (offset 0x06) held before that edge. It does not load zero.
- R6: Each overflow step produces `irq` high for exactly one clock, in the cycle right after the overflow edge. At all other times `irq` is low.
- R7: A bus write to the counter in the same cycle as a step wins. The counter takes the written value, and neither a reload nor an interrupt results.
- R8: Reset clears the divider, counter, modulo register and control register to zero, and `irq` to 0.
- R9: Reads return the divider high byte at 0x04, the counter at 0x05 and the modulo register at 0x06. At 0x07 they return {5'b11111, control[2:0]}. Every other offset reads 0xFF, and writes to other offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Machine-cycle enable, one pulse per machine cycle |
| addr | input | 8 | Register offset within the I/O page |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe, one write per cycle it is high |
| rdata | output | 8 | Read data for `addr` |
| irq | output | 1 | Timer-overflow interrupt request pulse |

## Verification
On every cycle the assertions check the following:
- the divider advances or holds as `cke` and the clear dictate;
- a divider write empties it;
- each step lands where the selected tap's low bits are zero;
- a disabled counter never steps;
- an overflow reloads the prior modulo value;
- a counter write takes effect;
- `irq` never lasts longer than one cycle.

Other behaviours depend on the sequence of events and only the bench scenarios can show them. These are the absolute periods for each rate code, the priority of a counter write that collides with an overflow (no interrupt at all), the read map including the padding bits and unused offsets, and the return to zero after a reset in the middle of a run.

// File: rtl/ptm_pkg.sv
package ptm_pkg;

  typedef enum logic [1:0] {
    RATE_1024 = 2'b00,
    RATE_16   = 2'b01,
    RATE_64   = 2'b10,
    RATE_256  = 2'b11
  } rate_e;

  // Number of divider low bits that make up one step period.
  function automatic int unsigned rate_bits(rate_e r);
    case (r)
      RATE_16:  return 4;
      RATE_64:  return 6;
      RATE_256: return 8;
      default:  return 10;
    endcase
  endfunction

  // All-ones pattern over those low bits.
  function automatic logic [31:0] rate_mask(rate_e r);
    return (32'd1 << rate_bits(r)) - 32'd1;
  endfunction

endpackage

// File: rtl/ptm_divider.sv
module ptm_divider
  import ptm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke_i,
  input  logic             clr_i,
  input  logic             en_i,
  input  rate_e            rate_i,
  output logic [DIV_W-1:0] div_o,
  output logic             tick_o
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] tap_mask;

  assign tap_mask = DIV_W'(rate_mask(rate_i));

  // A step is taken on the edge where the selected low bits roll over.
  assign tick_o = cke_i && !clr_i && en_i && ((div_q & tap_mask) == tap_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_q <= '0;
    else if (clr_i) div_q <= '0;
    else if (cke_i) div_q <= div_q + 1'b1;
  end

  assign div_o = div_q;

endmodule

// File: rtl/ptm_counter.sv
module ptm_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);

  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  assign ovf_o = tick_i && !wr_i && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (ovf_o)  cnt_q <= reload_i;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/prog_timer.sv
module prog_timer
  import ptm_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 16,
  parameter int BASE_OFF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam int CTRL_W   = 3;
  localparam int CTRL_PAD = DATA_W - CTRL_W;
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(BASE_OFF);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(BASE_OFF + 1);
  localparam logic [ADDR_W-1:0] A_MOD  = ADDR_W'(BASE_OFF + 2);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BASE_OFF + 3);

  // Named internal events, also observed by the checker.
  logic              div_clr, cnt_wr, mod_wr, ctrl_wr;
  logic              tick, ovf;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] cnt_q, mod_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              irq_q;

  assign div_clr = we && (addr == A_DIV);
  assign cnt_wr  = we && (addr == A_CNT);
  assign mod_wr  = we && (addr == A_MOD);
  assign ctrl_wr = we && (addr == A_CTRL);

  ptm_divider #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .cke_i  (cke),
    .clr_i  (div_clr),
    .en_i   (ctrl_q[2]),
    .rate_i (rate_e'(ctrl_q[1:0])),
    .div_o  (div_q),
    .tick_o (tick)
  );

  ptm_counter #(.W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .wr_i     (cnt_wr),
    .wdata_i  (wdata),
    .reload_i (mod_q),
    .cnt_o    (cnt_q),
    .ovf_o    (ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q  <= '0;
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mod_wr)  mod_q  <= wdata;
      if (ctrl_wr) ctrl_q <= wdata[CTRL_W-1:0];
      irq_q <= ovf;
    end
  end

  always_comb begin
    case (addr)
      A_DIV:   rdata = div_q[DIV_W-1 -: DATA_W];
      A_CNT:   rdata = cnt_q;
      A_MOD:   rdata = mod_q;
      A_CTRL:  rdata = {{CTRL_PAD{1'b1}}, ctrl_q};
      default: rdata = '1;
    endcase
  end

  assign irq = irq_q;

endmodule

// File: rtl/ptm_checker.sv
module ptm_checker #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cke,
  input logic [DATA_W-1:0] wdata,
  input logic              div_clr,
  input logic              cnt_wr,
  input logic              tick,
  input logic              ovf,
  input logic [DIV_W-1:0]  div_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [DATA_W-1:0] mod_q,
  input logic [2:0]        ctrl_q,
  input logic              irq
);

  logic [DIV_W-1:0] low_bits;

  always_comb begin
    case (ctrl_q[1:0])
      2'b01:   low_bits = DIV_W'(16'h000F);
      2'b10:   low_bits = DIV_W'(16'h003F);
      2'b11:   low_bits = DIV_W'(16'h00FF);
      default: low_bits = DIV_W'(16'h03FF);
    endcase
  end

  // R1
  div_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke && !div_clr) |=> (div_q == $past(div_q) + 1'b1));

  // R1
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && !div_clr) |=> $stable(div_q));

  // R2
  div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_clr |=> (div_q == '0));

  // R3
  tick_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((div_q & $past(low_bits)) == '0));

  // R4
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[2] && !cnt_wr) |=> $stable(cnt_q));

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt_q == $past(mod_q)));

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R6
  irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> irq);

  // R7
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt_q == $past(wdata)) && !irq);

endmodule

bind prog_timer ptm_checker #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cke     (cke),
  .wdata   (wdata),
  .div_clr (div_clr),
  .cnt_wr  (cnt_wr),
  .tick    (tick),
  .ovf     (ovf),
  .div_q   (div_q),
  .cnt_q   (cnt_q),
  .mod_q   (mod_q),
  .ctrl_q  (ctrl_q),
  .irq     (irq)
);

// File: tb/sim_prog_timer.sv
`timescale 1ns/1ps
module sim_prog_timer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       we = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cke_div = 1;
  int pulses = 0;
  bit done = 0;

  // Reference state
  int m_div = 0, m_cnt = 0, m_mod = 0, m_ctrl = 0;
  bit m_irq = 0;

  always #2.5 clk = ~clk;

  prog_timer u0 (
    .clk(clk), .rst_n(rst_n), .cke(cke), .addr(addr),
    .wdata(wdata), .we(we), .rdata(rdata), .irq(irq)
  );

  function automatic int period(int code);
    case (code)
      1: return 16;
      2: return 64;
      3: return 256;
      default: return 1024;
    endcase
  endfunction

  function automatic int exp_read(int a);
    case (a)
      4: return m_div / 256;
      5: return m_cnt;
      6: return m_mod;
      7: return 8'hF8 | m_ctrl;
      default: return 8'hFF;
    endcase
  endfunction

  always @(posedge clk) begin
    bit dw, cw, mw, tw, tk, nirq;
    int n;
    if (!rst_n) begin
      m_div = 0; m_cnt = 0; m_mod = 0; m_ctrl = 0; m_irq = 0;
    end else begin
      dw = we && addr == 8'h04;
      cw = we && addr == 8'h05;
      mw = we && addr == 8'h06;
      tw = we && addr == 8'h07;
      n = period(m_ctrl % 4);
      tk = cke && !dw && (m_ctrl / 4) == 1 && (m_div % n) == n - 1;
      nirq = 0;
      if (cw) m_cnt = wdata;
      else if (tk) begin
        if (m_cnt == 255) begin m_cnt = m_mod; nirq = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (mw) m_mod = wdata;
      if (tw) m_ctrl = wdata % 8;
      if (dw) m_div = 0;
      else if (cke) m_div = (m_div + 1) % 65536;
      m_irq = nirq;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // One clock: compare at the falling edge, then prepare the next inputs.
  task automatic step();
    @(negedge clk);
    cyc++;
    chk("R6 irq vs model", int'(irq), int'(m_irq));
    chk("R9 rdata vs model", int'(rdata), exp_read(int'(addr)));
    if (irq) pulses++;
    cke = (cyc % cke_div) == 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output int v);
    addr = a; we = 1'b0;
    step();
    v = int'(rdata);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int v;
    run(3);
    // R8 and R9: state after reset
    rst_n = 1'b1;
    rd(8'h04, v); chk("R8 divider after reset", v, 0);
    rd(8'h05, v); chk("R8 counter after reset", v, 0);
    rd(8'h06, v); chk("R8 modulo after reset", v, 0);
    rd(8'h07, v); chk("R8 R9 control reads padded", v, 8'hF8);
    chk("R8 irq after reset", int'(irq), 0);
    // R9: unused offsets
    rd(8'h00, v); chk("R9 unused offset", v, 8'hFF);
    wr(8'h08, 8'h55);
    rd(8'h06, v); chk("R9 stray write ignored", v, 0);
    // R1: divider upper byte
    cke_div = 1;
    wr(8'h04, 8'h12);
    run(600);
    rd(8'h04, v); chk("R1 divider high byte", v, 2);
    // R2: clear by write
    run(400);
    wr(8'h04, 8'h00);
    rd(8'h04, v); chk("R2 divider cleared", v, 0);
    // R3: each rate code
    for (int s = 0; s < 4; s++) begin
      wr(8'h07, 8'(4 + s));
      wr(8'h05, 8'h00);
      wr(8'h04, 8'h00);
      run(5 * period(s));
      rd(8'h05, v); chk($sformatf("R3 five steps rate %0d", s), v, 5);
    end
    // R4: disabled counter holds
    wr(8'h07, 8'h01);
    wr(8'h05, 8'h42);
    run(200);
    rd(8'h05, v); chk("R4 disabled holds", v, 8'h42);
    // R5 R6: overflow with rate 16
    wr(8'h06, 8'hA0);
    wr(8'h05, 8'hFE);
    wr(8'h04, 8'h00);
    wr(8'h07, 8'h05);
    pulses = 0;
    run(40);
    chk("R6 one pulse per overflow", pulses, 1);
    rd(8'h05, v); chk("R5 reload from modulo", v, 8'hA0);
    // R5 R6: slow rate with sparse cke
    wr(8'h07, 8'h01);
    wr(8'h06, 8'h33);
    wr(8'h05, 8'hFF);
    wr(8'h04, 8'h00);
    cke_div = 3;
    wr(8'h07, 8'h04);
    pulses = 0;
    run(3300);
    chk("R6 one pulse at rate 1024", pulses, 1);
    rd(8'h05, v); chk("R5 reload at rate 1024", v, 8'h33);
    cke_div = 1;
    // R7: write collides with overflow
    wr(8'h07, 8'h01);
    wr(8'h06, 8'h10);
    wr(8'h05, 8'hFF);
    wr(8'h07, 8'h05);
    pulses = 0;
    for (int i = 0; i < 60; i++) wr(8'h05, 8'hFF);
    chk("R7 no irq when write wins", pulses, 0);
    // R8: reset mid-run
    wr(8'h06, 8'h77);
    rst_n = 1'b0;
    run(2);
    rst_n = 1'b1;
    rd(8'h06, v); chk("R8 modulo after mid reset", v, 0);
    rd(8'h07, v); chk("R8 control after mid reset", v, 8'hF8);
    done = 1;
    summary();
    $finish;
  end

endmodule